// File: doc/BRIEF.md
# Tandem Banyan Switching Element Controller

This block is the setting logic for one 2x2 bit-serial switching element in a banyan stage of a tandem-banyan fabric. Two serial cell streams enter, one on each input. Each cell starts with a header: an activity bit, a conflict bit, a priority field and an address field whose first bit is the destination bit for this stage. The payload follows the header. Once per time slot the element chooses a bar state (input 0 to output 0, input 1 to output 1) or a cross state (input 0 to output 1, input 1 to output 0). The choice follows a fixed order of precedence: activity first, then the conflict bits, then priority. An active cell that the chosen state sends to the wrong output has its conflict bit set, so the next banyan in the tandem can tell it was deflected.

The element also rotates each cell's address field left by one bit, so that the next stage finds its own routing bit at the front of the field. Every bit leaves the element a fixed 3 + PRIO_W bit times after it arrived, the same at every stage. An external strobe marks the first bit of each slot.

Top module: `tbs_switch_element`

## Requirements
- R1: After reset both outputs are 0 and the element is in the bar state.
- R2: When both cells in a slot have activity bit 0, the element keeps the state it had in the previous slot.
- R3: When exactly one cell is active, the state sends that cell to the output its destination bit names. Destination bit 0 means output 0 and 1 means output 1.
- R4: When both cells are active and both have conflict bit 1, the state is left unchanged.
- R5: When both cells are active and exactly one has conflict bit 0, that cell's destination bit sets the state.
- R6: When both cells are active with conflict bit 0, the cell with the larger unsigned priority value sets the state.
- R7: When both active cells have conflict bit 0 and equal priority, input 0 sets the state.
- R8: An active cell that leaves on the output its destination bit does not name has conflict bit 1 at the output. Any other cell leaves with its conflict bit unchanged.
- R9: The address field leaves rotated left by one bit. For field bits a[AW-1] (sent first) down to a[0], the output is a[AW-2:0] followed by a[AW-1].
- R10: Every bit leaves exactly 3 + PRIO_W bit times after it arrived. The activity bit, the priority field and the payload leave unchanged.
- R11: The wire order is: activity, conflict, priority MSB first, address, payload. A slot is CELL_W = 2 + PRIO_W + ADDR_W + PAY_W bits long, and slot_start is high together with its activity bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_start | input | 1 | High during the first (activity) bit of each slot |
| in_bit | input | 2 | Serial cell inputs; bit i is input i |
| out_bit | output | 2 | Serial cell outputs after switching and header rewrite; bit i is output i |

## Verification
Every output bit of a slot is due 3 + PRIO_W cycles after the matching input bit. A slot whose first bit is driven in cycle t therefore appears complete on both outputs in cycles t+LAT to t+LAT+CELL_W-1. The new switch state and conflict marks take effect in cycle t+LAT. The driver works out both expected output cells from the rules and queues them with that due cycle. The monitor samples on the falling edge, gathers exactly CELL_W bits from the due cycle onward and compares whole cells. Slots are sent back to back, so the bench also covers the overlap in which the previous cell's tail is still leaving while the next header arrives.

// File: rtl/tbs_pkg.sv
// Package: shared decision function for the tandem banyan switching element.
// Assumes state encoding 0 = bar (straight), 1 = cross.
package tbs_pkg;

    // Next switch state from the header fields of both cells; cur is the held state.
    function automatic logic next_cross(
        input logic [1:0] act,
        input logic [1:0] conf,
        input logic       p0_wins,
        input logic [1:0] dbit,
        input logic       cur
    );
        logic r;
        unique case (act)
            2'b00:   r = cur;        // idle slot, hold
            2'b01:   r = dbit[0];    // only input 0 active
            2'b10:   r = !dbit[1];   // only input 1 active
            default: begin
                unique case (conf)
                    2'b11:   r = cur;        // both already deflected
                    2'b10:   r = dbit[0];    // input 0 still clean
                    2'b01:   r = !dbit[1];   // input 1 still clean
                    default: r = p0_wins ? dbit[0] : !dbit[1];
                endcase
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tbs_slot_timer.sv
// Slot timer: tracks the bit position of the arriving cell and of the cell
// currently leaving (delayed by LAT). Assumes slot_start marks bit 0.
module tbs_slot_timer #(
    parameter int CELL_W   = 15,
    parameter int LAT      = 5,
    parameter int ADDR_POS = 4,
    localparam int POS_W   = $clog2(CELL_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_start,
    output logic [POS_W-1:0] pos_in,
    output logic [POS_W-1:0] pos_out,
    output logic             dec_en
);
    localparam logic [POS_W-1:0] P_LAST = POS_W'(CELL_W - 1);
    localparam logic [POS_W-1:0] P_LAT  = POS_W'(LAT);
    localparam logic [POS_W-1:0] P_BACK = POS_W'(CELL_W - LAT);
    localparam logic [POS_W-1:0] P_DEC  = POS_W'(ADDR_POS);

    logic [POS_W-1:0] pos_q;

    // Position of the bit on the inputs this cycle.
    always_comb begin
        if (slot_start)           pos_in = '0;
        else if (pos_q == P_LAST) pos_in = '0;
        else                      pos_in = pos_q + 1'b1;
    end

    // Position of the bit leaving this cycle (LAT bits behind, modulo slot).
    always_comb begin
        if (pos_in >= P_LAT) pos_out = pos_in - P_LAT;
        else                 pos_out = pos_in + P_BACK;
    end

    // Decision happens while the stage address bit is on the inputs.
    assign dec_en = (pos_in == P_DEC);

    // Hold the last position.
    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= P_LAST;
        else        pos_q <= pos_in;
    end
endmodule

// File: rtl/tbs_hdr_capture.sv
// Header capture for one input: latches the activity and conflict bits and
// shifts in the priority field (MSB first). With PRIO_W = 0 the priority is
// a constant 0, so all cells tie.
module tbs_hdr_capture #(
    parameter int PRIO_W    = 2,
    parameter int POS_W     = 4,
    localparam int PRIO_X   = (PRIO_W > 0) ? PRIO_W : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_bit,
    input  logic [POS_W-1:0]  pos_in,
    output logic              act,
    output logic              conf,
    output logic [PRIO_X-1:0] prio
);
    // Latch activity (bit 0) and conflict (bit 1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act  <= 1'b0;
            conf <= 1'b0;
        end else begin
            if (pos_in == POS_W'(0)) act  <= in_bit;
            if (pos_in == POS_W'(1)) conf <= in_bit;
        end
    end

    generate
        if (PRIO_W > 0) begin : g_prio
            // Shift in priority bits at positions 2 .. 1+PRIO_W.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    prio <= '0;
                else if (pos_in >= POS_W'(2) && pos_in <= POS_W'(1 + PRIO_W))
                    prio <= (prio << 1) | PRIO_X'(in_bit);
            end
        end else begin : g_noprio
            assign prio = '0;
        end
    endgenerate
endmodule

// File: rtl/tbs_route_decide.sv
// Route decision: once per slot, while the stage address bits are on the
// inputs, it sets the bar/cross state and the outgoing conflict bits.
// Assumes the header registers hold the current cell's fields at that time.
module tbs_route_decide #(
    parameter int PRIO_X = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_en,
    input  logic [1:0]        act,
    input  logic [1:0]        conf,
    input  logic [PRIO_X-1:0] prio0,
    input  logic [PRIO_X-1:0] prio1,
    input  logic [1:0]        dbit,
    output logic              cross_q,
    output logic [1:0]        conf_out_q
);
    import tbs_pkg::*;

    logic       nxt;
    logic [1:0] mis;

    // Next state and misroute flags from the precedence rules.
    always_comb begin
        nxt    = next_cross(act, conf, (prio0 >= prio1), dbit, cross_q);
        mis[0] = act[0] & (nxt != dbit[0]);
        mis[1] = act[1] & (nxt == dbit[1]);
    end

    // Register the state and the conflict bits to send out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cross_q    <= 1'b0;
            conf_out_q <= 2'b00;
        end else if (dec_en) begin
            cross_q    <= nxt;
            conf_out_q <= conf | mis;
        end
    end
endmodule

// File: rtl/tbs_stream_rewrite.sv
// Stream rewrite for one input: delays the serial stream by LAT bits,
// puts in the new conflict bit and rotates the address field left by one.
// Assumes the hold registers stay valid until the delayed field leaves.
module tbs_stream_rewrite #(
    parameter int LAT      = 5,
    parameter int ADDR_POS = 4,
    parameter int ADDR_W   = 3,
    parameter int POS_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_bit,
    input  logic [POS_W-1:0] pos_in,
    input  logic [POS_W-1:0] pos_out,
    input  logic             conf_new,
    output logic             x_bit
);
    localparam logic [POS_W-1:0] P_CONF  = POS_W'(1);
    localparam logic [POS_W-1:0] P_AFST  = POS_W'(ADDR_POS);
    localparam logic [POS_W-1:0] P_ALST  = POS_W'(ADDR_POS + ADDR_W - 1);

    logic [LAT-1:0] dline;
    logic           lead_addr;

    // Delay line: dline[k] holds the bit that arrived k+1 cycles ago.
    always_ff @(posedge clk) begin
        if (!rst_n) dline <= '0;
        else        dline <= {dline[LAT-2:0], in_bit};
    end

    // Keep the leading address bit to append at the end of the field.
    always_ff @(posedge clk) begin
        if (!rst_n)                lead_addr <= 1'b0;
        else if (pos_in == P_AFST) lead_addr <= in_bit;
    end

    // Choose the outgoing bit by output position.
    always_comb begin
        if (pos_out == P_CONF)
            x_bit = conf_new;
        else if (pos_out == P_ALST)
            x_bit = lead_addr;
        else if (pos_out >= P_AFST && pos_out < P_ALST)
            x_bit = dline[LAT-2];
        else
            x_bit = dline[LAT-1];
    end
endmodule

// File: rtl/tbs_switch_element.sv
// Top: 2x2 bit-serial tandem banyan switching element. Bit latency is
// 3 + PRIO_W. Assumes slots arrive back to back, with slot_start on bit 0,
// and PAY_W >= 1.
module tbs_switch_element #(
    parameter int PRIO_W = 2,
    parameter int ADDR_W = 3,
    parameter int PAY_W  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_start,
    input  logic [1:0] in_bit,
    output logic [1:0] out_bit
);
    localparam int CELL_W   = 2 + PRIO_W + ADDR_W + PAY_W;
    localparam int LAT      = 3 + PRIO_W;
    localparam int ADDR_POS = 2 + PRIO_W;
    localparam int POS_W    = $clog2(CELL_W);
    localparam int PRIO_X   = (PRIO_W > 0) ? PRIO_W : 1;

    logic [POS_W-1:0]  pos_in;
    logic [POS_W-1:0]  pos_out;
    logic              dec_en;
    logic [1:0]        hdr_act;
    logic [1:0]        hdr_conf;
    logic [PRIO_X-1:0] hdr_prio [2];
    logic              sw_cross;
    logic [1:0]        cflag_hold;
    logic [1:0]        rw_bit;

    tbs_slot_timer #(.CELL_W(CELL_W), .LAT(LAT), .ADDR_POS(ADDR_POS)) u_timer (
        .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
        .pos_in(pos_in), .pos_out(pos_out), .dec_en(dec_en)
    );

    generate
        for (genvar i = 0; i < 2; i++) begin : g_port
            tbs_hdr_capture #(.PRIO_W(PRIO_W), .POS_W(POS_W)) u_cap (
                .clk(clk), .rst_n(rst_n), .in_bit(in_bit[i]), .pos_in(pos_in),
                .act(hdr_act[i]), .conf(hdr_conf[i]), .prio(hdr_prio[i])
            );
            tbs_stream_rewrite #(.LAT(LAT), .ADDR_POS(ADDR_POS), .ADDR_W(ADDR_W),
                                 .POS_W(POS_W)) u_rw (
                .clk(clk), .rst_n(rst_n), .in_bit(in_bit[i]), .pos_in(pos_in),
                .pos_out(pos_out), .conf_new(cflag_hold[i]), .x_bit(rw_bit[i])
            );
        end
    endgenerate

    tbs_route_decide #(.PRIO_X(PRIO_X)) u_dec (
        .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .act(hdr_act), .conf(hdr_conf),
        .prio0(hdr_prio[0]), .prio1(hdr_prio[1]), .dbit(in_bit),
        .cross_q(sw_cross), .conf_out_q(cflag_hold)
    );

    // Crossbar: bar passes straight through, cross swaps the two streams.
    always_comb begin
        out_bit[0] = sw_cross ? rw_bit[1] : rw_bit[0];
        out_bit[1] = sw_cross ? rw_bit[0] : rw_bit[1];
    end
endmodule

// File: rtl/tbs_switch_element_chk.sv
// Checker for tbs_switch_element: properties on the slot decision.
module tbs_switch_element_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dec_en,
    input logic [1:0] hdr_act,
    input logic [1:0] hdr_conf,
    input logic [1:0] in_bit,
    input logic       sw_cross,
    input logic [1:0] cflag_hold
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && hdr_act == 2'b00) |=> $stable(sw_cross));

    // R3
    single0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && hdr_act == 2'b01) |=> (sw_cross == $past(in_bit[0])));

    // R3
    single1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && hdr_act == 2'b10) |=> (sw_cross == !$past(in_bit[1])));

    // R4
    blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && hdr_act == 2'b11 && hdr_conf == 2'b11) |=> $stable(sw_cross));

    // R8
    one_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && hdr_act == 2'b11 && hdr_conf == 2'b00 && in_bit[0] == in_bit[1])
        |=> ($countones(cflag_hold) == 1));

    // R8
    no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && hdr_act == 2'b11 && hdr_conf == 2'b00 && in_bit[0] != in_bit[1])
        |=> (cflag_hold == 2'b00));
endmodule

bind tbs_switch_element tbs_switch_element_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .hdr_act(hdr_act),
    .hdr_conf(hdr_conf), .in_bit(in_bit), .sw_cross(sw_cross),
    .cflag_hold(cflag_hold)
);

// File: tb/test_tbs_switch_element.sv
// Scoreboard bench: the driver queues the expected output cells with their
// due cycle, and the monitor gathers the output bits and compares them.
module test_tbs_switch_element;
    localparam int PW   = 2;
    localparam int AW   = 3;
    localparam int PLW  = 8;
    localparam int CELL = 2 + PW + AW + PLW;
    localparam int LAT  = 3 + PW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_start = 1'b0;
    logic [1:0] in_bit = 2'b00;
    logic [1:0] out_bit;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;
    logic m_cross = 1'b0;

    int              due_q[$];
    logic [CELL-1:0] e0_q[$];
    logic [CELL-1:0] e1_q[$];
    string           tag_q[$];
    logic [CELL-1:0] got0, got1;

    tbs_switch_element #(.PRIO_W(PW), .ADDR_W(AW), .PAY_W(PLW)) i_tbs_switch_element (
        .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
        .in_bit(in_bit), .out_bit(out_bit)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected outgoing cell: conflict updated, address rotated (R9).
    function automatic logic [CELL-1:0] out_cell(logic a, logic c, logic [PW-1:0] p,
                                                 logic [AW-1:0] d, logic [PLW-1:0] pl,
                                                 logic mis);
        return {a, c | mis, p, d[AW-2:0], d[AW-1], pl};
    endfunction

    // Driver: model the decision, queue the expected cells, drive one slot.
    task automatic send_slot(input logic a0, input logic c0, input logic [PW-1:0] p0,
                             input logic [AW-1:0] d0, input logic [PLW-1:0] pl0,
                             input logic a1, input logic c1, input logic [PW-1:0] p1,
                             input logic [AW-1:0] d1, input logic [PLW-1:0] pl1,
                             input string tag);
        logic s0, s1, nc, mis0, mis1;
        logic [CELL-1:0] v0, v1;
        s0 = d0[AW-1];
        s1 = d1[AW-1];
        if (!a0 && !a1)            nc = m_cross;
        else if (a0 && !a1)        nc = s0;
        else if (!a0 && a1)        nc = !s1;
        else if (c0 && c1)         nc = m_cross;
        else if (!c0 && c1)        nc = s0;
        else if (c0 && !c1)        nc = !s1;
        else if (p0 >= p1)         nc = s0;
        else                       nc = !s1;
        m_cross = nc;
        mis0 = a0 && (nc != s0);
        mis1 = a1 && ((!nc) != s1);
        v0 = {a0, c0, p0, d0, pl0};
        v1 = {a1, c1, p1, d1, pl1};
        due_q.push_back(cyc + LAT);
        tag_q.push_back(tag);
        if (!nc) begin
            e0_q.push_back(out_cell(a0, c0, p0, d0, pl0, mis0));
            e1_q.push_back(out_cell(a1, c1, p1, d1, pl1, mis1));
        end else begin
            e0_q.push_back(out_cell(a1, c1, p1, d1, pl1, mis1));
            e1_q.push_back(out_cell(a0, c0, p0, d0, pl0, mis0));
        end
        for (int k = 0; k < CELL; k++) begin
            slot_start = (k == 0);
            in_bit[0]  = v0[CELL-1-k];
            in_bit[1]  = v1[CELL-1-k];
            @(posedge clk);
            #1;
        end
        slot_start = 1'b0;
    endtask

    // Monitor: gather CELL bits from the due cycle and compare whole cells.
    always @(negedge clk) begin
        if (rst_n && due_q.size() > 0 && cyc >= due_q[0]) begin
            int idx;
            idx = cyc - due_q[0];
            got0[CELL-1-idx] = out_bit[0];
            got1[CELL-1-idx] = out_bit[1];
            if (idx == CELL - 1) begin
                n_chk += 2;
                if (got0 !== e0_q[0]) begin
                    n_err++;
                    $display("FAIL %s out0: got %b expected %b", tag_q[0], got0, e0_q[0]);
                end
                if (got1 !== e1_q[0]) begin
                    n_err++;
                    $display("FAIL %s out1: got %b expected %b", tag_q[0], got1, e1_q[0]);
                end
                void'(due_q.pop_front());
                void'(e0_q.pop_front());
                void'(e1_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: outputs low after reset
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            n_chk++;
            if (out_bit !== 2'b00) begin
                n_err++;
                $display("FAIL R1 reset outputs: got %b expected 00", out_bit);
            end
        end
        @(posedge clk);
        #1;
        // R1 R2: idle slot after reset stays bar
        send_slot(0, 0, 2'd0, 3'b101, 8'hA5, 0, 1, 2'd3, 3'b010, 8'h3C, "R1/R2 idle after reset");
        // R3: only input 0 active, wants output 1 -> cross
        send_slot(1, 0, 2'd1, 3'b110, 8'h81, 0, 0, 2'd0, 3'b000, 8'h7E, "R3 single input 0");
        // R2: idle slot keeps cross
        send_slot(0, 0, 2'd2, 3'b011, 8'h0F, 0, 0, 2'd1, 3'b100, 8'hF0, "R2 idle keeps cross");
        // R3: only input 1 active, wants output 1 -> bar
        send_slot(0, 0, 2'd0, 3'b000, 8'h55, 1, 0, 2'd2, 3'b101, 8'hC3, "R3 single input 1");
        // R4: both active, both deflected -> hold bar
        send_slot(1, 1, 2'd0, 3'b100, 8'h12, 1, 1, 2'd3, 3'b110, 8'h34, "R4 both deflected");
        // R5: only input 1 clean, wants output 0 -> cross; input 0 misrouted
        send_slot(1, 1, 2'd3, 3'b011, 8'h9A, 1, 0, 2'd0, 3'b001, 8'hBC, "R5 input 1 clean");
        // R5: only input 0 clean, wants output 0 -> bar
        send_slot(1, 0, 2'd0, 3'b010, 8'hDE, 1, 1, 2'd3, 3'b000, 8'h21, "R5 input 0 clean");
        // R6 R8: input 1 higher priority, both want 0 -> cross, input 0 marked
        send_slot(1, 0, 2'd1, 3'b001, 8'h66, 1, 0, 2'd3, 3'b011, 8'h99, "R6/R8 input 1 wins");
        // R6 R8: input 0 higher priority, both want 1 -> cross, input 1 marked
        send_slot(1, 0, 2'd2, 3'b111, 8'hE7, 1, 0, 2'd1, 3'b100, 8'h18, "R6/R8 input 0 wins");
        // R7 R8: equal priority, both want 0 -> input 0 wins, bar
        send_slot(1, 0, 2'd2, 3'b010, 8'h42, 1, 0, 2'd2, 3'b001, 8'h24, "R7/R8 tie to input 0");
        // R8: no clash, input 0 wants 1, input 1 wants 0 -> cross, nobody marked
        send_slot(1, 0, 2'd3, 3'b101, 8'hFF, 1, 0, 2'd3, 3'b011, 8'h01, "R8 no clash");
        // R9 R10 R11: address rotation, latency and field order with mixed fields
        send_slot(1, 0, 2'd1, 3'b100, 8'hC9, 1, 1, 2'd2, 3'b011, 8'h6D, "R9/R10/R11 rotate");
        send_slot(0, 0, 2'd0, 3'b000, 8'h00, 0, 0, 2'd0, 3'b000, 8'h00, "R10 flush");
        repeat (CELL + LAT) @(posedge clk);
        #1;
        n_chk++;
        if (due_q.size() != 0) begin
            n_err++;
            $display("FAIL R10 pending cells: got %0d expected 0", due_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule